// File: doc/BRIEF.md
# Majority-Vote Register Sampler

This block sits between a requester and a register whose read value cannot be trusted on a single access. When a read is requested, the block reads the target register many times in back-to-back cycles and keeps every sample. It then works through the samples and returns the value that occurs most often. Working through the samples means keeping a table of the distinct values seen so far, each with the number of times it has appeared.

The samples are processed in the order they were captured. Each sample is looked up in the table one entry per cycle, starting from the oldest entry. If the sample matches an entry, that entry's count goes up by one. If no entry matches, the sample is added as a new entry with a count of one. A running best count changes only when a count strictly exceeds it, so on a tie the value that reached the count first is kept. As soon as the best count is more than half the number of samples, the rest of the samples are skipped and the answer is given at once.

The answer is delivered as a one-cycle valid pulse. Requests that arrive while a read is in progress are dropped.

Top module: `mode_read_filter`

## Requirements
- R1: While reset is asserted, and until a request is accepted, `rsp_valid` and `tgt_rd` are both 0.
- R2: A request is accepted on a rising edge where the block is idle and `req_valid` is 1. `tgt_rd` is then high for exactly NSAMP consecutive cycles, starting in the cycle after that edge. Throughout those cycles `tgt_addr` equals the `req_addr` sampled at acceptance, and one sample of `tgt_data` is taken on each of those edges.
- R3: A request presented while a read is in progress is ignored. This includes the cycle in which `rsp_valid` is high. Such a request triggers no extra target reads, no extra response and no change of `tgt_addr`. A request held high is accepted again on the first edge after the response cycle.
- R4: The returned `rsp_data` is the value with the highest occurrence count among the samples that were processed.
- R5: When two values have equal counts, the one whose count reached that level first, in capture order, is returned. When all samples are distinct, the result is the first sample.
- R6: Processing stops right after the sample that brings some count above NSAMP/2 (integer division). With NSAMP = 100 this happens at a count of 51.
- R7: `rsp_valid` is high for exactly one cycle per accepted request, and `rsp_data` holds the result in that cycle.
- R8: Let E be the acceptance edge. `rsp_valid` is high in the cycle after edge E + NSAMP + C, where C is the sum, over the processed samples, of (k + 1). Here k is the 0-based position of the sample's value in the table, with values ordered by first appearance.
- R9: The count table starts empty on every accepted request. Values and counts from an earlier request have no effect on the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | AW | Address of the register to read |
| rsp_valid | output | 1 | One-cycle pulse marking the result |
| rsp_data | output | DW | Majority (mode) value |
| tgt_rd | output | 1 | Read strobe to the target register |
| tgt_addr | output | AW | Address driven to the target |
| tgt_data | input | DW | Read data from the target, valid in the same cycle |

## Verification
The response cycle and the acceptance of the next request can fall next to each other. The bench holds `req_valid` high across two whole reads. The request that is present during the response pulse must be dropped, and the next edge must start a fresh capture. The bench judges this against its cycle-exact model of strobes, pulse position and data.

The last lookup of a sample can also coincide with the early-stop decision. This is provoked with patterns that reach the majority threshold partway through, and with patterns that never reach it. The position of the pulse then shows whether processing stopped on the right sample.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_CNT  = 2'd2,
    ST_DONE = 2'd3
  } mrf_state_e;
endpackage

// File: rtl/mrf_sample_store.sv
module mrf_sample_store #(
  parameter int DW = 32,
  parameter int N  = 100,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic          slot_en;
    logic [DW-1:0] slot_q;
    assign slot_en = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= wr_data;
    end
    assign slot_arr[g] = slot_q;
  end

  assign rd_data = slot_arr[rd_idx];
endmodule

// File: rtl/mrf_tally_table.sv
module mrf_tally_table #(
  parameter int DW = 32,
  parameter int N  = 100,
  parameter int IW = 7,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_val,
  input  logic [CW-1:0] wr_cnt,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_val,
  output logic [CW-1:0] rd_cnt
);
  logic [DW-1:0] val_arr [N];
  logic [CW-1:0] cnt_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic          ent_en;
    logic [DW-1:0] val_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    assign ent_en = wr_en && (wr_idx == IW'(g));
    always_comb begin
      cnt_d = cnt_q;
      if (clr)         cnt_d = '0;
      else if (ent_en) cnt_d = wr_cnt;
    end
    always_ff @(posedge clk) begin
      if (ent_en) val_q <= wr_val;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr || ent_en)  cnt_q <= cnt_d;
    end
    assign val_arr[g] = val_q;
    assign cnt_arr[g] = cnt_q;
  end

  assign rd_val = val_arr[rd_idx];
  assign rd_cnt = cnt_arr[rd_idx];

  // R4: every count written is a real occurrence count (1..N)
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_cnt != '0) && (wr_cnt <= CW'(N)));
endmodule

// File: rtl/mrf_ctrl.sv
module mrf_ctrl
  import mrf_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int N  = 100,
  parameter int IW = 7,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          tgt_rd,
  output logic [AW-1:0] tgt_addr,
  output logic [IW-1:0] smp_idx,
  input  logic [DW-1:0] smp_val,
  output logic [IW-1:0] tab_idx,
  input  logic [DW-1:0] tab_val,
  input  logic [CW-1:0] tab_cnt,
  output logic          tab_clr,
  output logic          tab_wr,
  output logic [CW-1:0] tab_wr_cnt
);
  localparam int HALF = N / 2;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  mrf_state_e    state_q, state_d;
  logic [IW-1:0] s_q, s_d;
  logic [IW-1:0] j_q, j_d;
  logic [IW-1:0] used_q, used_d;
  logic [CW-1:0] max_q, max_d;
  logic [DW-1:0] res_q, res_d;
  logic [AW-1:0] addr_q;
  logic          addr_en, res_en, cnt_en;

  logic          hit, app, step, better, stop;
  logic [CW-1:0] new_cnt, max_n;

  always_comb begin
    hit     = (j_q < used_q) && (tab_val == smp_val);
    app     = (j_q == used_q);
    step    = (state_q == ST_CNT) && (hit || app);
    new_cnt = hit ? (tab_cnt + CW'(1)) : CW'(1);
    better  = new_cnt > max_q;
    max_n   = better ? new_cnt : max_q;
    stop    = (max_n > CW'(HALF)) || (s_q == LAST);
  end

  always_comb begin
    state_d = state_q;
    s_d     = s_q;
    j_d     = j_q;
    used_d  = used_q;
    max_d   = max_q;
    res_d   = res_q;
    addr_en = 1'b0;
    res_en  = 1'b0;
    cnt_en  = 1'b0;
    tab_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_CAPT;
          s_d     = '0;
          j_d     = '0;
          used_d  = '0;
          max_d   = '0;
          addr_en = 1'b1;
          tab_clr = 1'b1;
          cnt_en  = 1'b1;
        end
      end
      ST_CAPT: begin
        cnt_en = 1'b1;
        if (s_q == LAST) begin
          state_d = ST_CNT;
          s_d     = '0;
        end else begin
          s_d = s_q + IW'(1);
        end
      end
      ST_CNT: begin
        cnt_en = 1'b1;
        if (step) begin
          if (app) used_d = used_q + IW'(1);
          if (better) begin
            max_d  = new_cnt;
            res_d  = smp_val;
            res_en = 1'b1;
          end
          j_d = '0;
          if (stop) state_d = ST_DONE;
          else      s_d     = s_q + IW'(1);
        end else begin
          j_d = j_q + IW'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q    <= '0;
      j_q    <= '0;
      used_q <= '0;
      max_q  <= '0;
    end else if (cnt_en) begin
      s_q    <= s_d;
      j_q    <= j_d;
      used_q <= used_d;
      max_q  <= max_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign rsp_valid  = (state_q == ST_DONE);
  assign rsp_data   = res_q;
  assign tgt_rd     = (state_q == ST_CAPT);
  assign tgt_addr   = addr_q;
  assign smp_idx    = s_q;
  assign tab_idx    = j_q;
  assign tab_wr     = step;
  assign tab_wr_cnt = new_cnt;

  // R2: address held steady over the whole capture burst
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_rd && $past(tgt_rd)) |-> $stable(tgt_addr));
  // R7: response is a single-cycle pulse
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R3: a capture burst only begins from an idle request
  p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_rd) |-> $past(req_valid));
  // R3: no target read overlaps the response cycle
  p_no_rd_at_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !tgt_rd);
  // R6: the best count never goes past the first value above half
  p_max_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    max_q <= CW'(HALF + 1));
  // R9: table occupancy never exceeds the sample count
  p_used_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= IW'(N));
endmodule

// File: rtl/mode_read_filter.sv
module mode_read_filter #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int NSAMP = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          tgt_rd,
  output logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data
);
  localparam int IW = $clog2(NSAMP + 1);
  localparam int CW = $clog2(NSAMP + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [IW-1:0] smp_idx, tab_idx;
  logic [DW-1:0] smp_val, tab_val;
  logic [CW-1:0] tab_cnt, tab_wr_cnt;
  logic          tab_clr, tab_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mrf_sample_store #(.DW(DW), .N(NSAMP), .IW(IW)) u_store (
    .clk     (clk),
    .wr_en   (tgt_rd),
    .wr_idx  (smp_idx),
    .wr_data (tgt_data),
    .rd_idx  (smp_idx),
    .rd_data (smp_val)
  );

  mrf_tally_table #(.DW(DW), .N(NSAMP), .IW(IW), .CW(CW)) u_table (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (tab_clr),
    .wr_en  (tab_wr),
    .wr_idx (tab_idx),
    .wr_val (smp_val),
    .wr_cnt (tab_wr_cnt),
    .rd_idx (tab_idx),
    .rd_val (tab_val),
    .rd_cnt (tab_cnt)
  );

  mrf_ctrl #(.DW(DW), .AW(AW), .N(NSAMP), .IW(IW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .tgt_rd     (tgt_rd),
    .tgt_addr   (tgt_addr),
    .smp_idx    (smp_idx),
    .smp_val    (smp_val),
    .tab_idx    (tab_idx),
    .tab_val    (tab_val),
    .tab_cnt    (tab_cnt),
    .tab_clr    (tab_clr),
    .tab_wr     (tab_wr),
    .tab_wr_cnt (tab_wr_cnt)
  );
endmodule

// File: tb/sim_mode_read_filter.sv
module sim_mode_read_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 100;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int WDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          tgt_rd;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mode_read_filter #(.DW(DW), .AW(AW), .NSAMP(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tgt_rd(tgt_rd),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  logic [DW-1:0] pat [NS];
  int rd_idx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_idx <= 0;
    else if (tgt_rd) rd_idx <= (rd_idx + 1) % NS;
  end
  assign tgt_data = pat[rd_idx];

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";
  bit started = 0;

  task automatic chk(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  // behavioural reference: mode with first-to-reach tie rule and early stop
  function automatic void model_run(output logic [DW-1:0] v, output int c);
    logic [DW-1:0] vals[$];
    int cnts[$];
    int mx;
    mx = 0; c = 0; v = '0;
    for (int i = 0; i < NS; i++) begin
      int k;
      k = -1;
      for (int e = 0; e < vals.size(); e++)
        if (vals[e] == pat[i]) begin k = e; break; end
      if (k < 0) begin
        vals.push_back(pat[i]); cnts.push_back(1); k = vals.size() - 1;
      end else cnts[k]++;
      c += k + 1;
      if (cnts[k] > mx) begin mx = cnts[k]; v = pat[i]; end
      if (mx > NS / 2) break;
    end
  endfunction

  bit            m_busy = 0;
  int            m_t = 0, m_c = 0, n_done = 0;
  logic [DW-1:0] m_v;
  logic [AW-1:0] m_a;

  always @(posedge clk) begin
    if (!rst_n || !started) m_busy = 0;
    else if (m_busy) begin
      if (m_t == NS + m_c) begin m_busy = 0; n_done++; end
      else m_t++;
    end else if (req_valid) begin
      m_busy = 1; m_t = 0; m_a = req_addr;
      model_run(m_v, m_c);
    end
  end

  always @(negedge clk) begin
    if (rst_n && started) begin
      bit e_rd, e_vl;
      e_rd = m_busy && (m_t < NS);
      e_vl = m_busy && (m_t == NS + m_c);
      chk("R2", "tgt_rd", DW'(tgt_rd), DW'(e_rd));
      if (e_rd) chk("R2", "tgt_addr", DW'(tgt_addr), DW'(m_a));
      chk(cur_tag, "rsp_valid", DW'(rsp_valid), DW'(e_vl));
      if (e_vl) chk(cur_tag, "rsp_data", rsp_data, m_v);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run_req(string tag, logic [AW-1:0] a, int poke_at);
    cur_tag = tag;
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      req_valid = 1'b1; req_addr = ~a;
      @(negedge clk); req_valid = 1'b0;
    end
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    for (int i = 0; i < NS; i++) pat[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rsp_valid in reset", DW'(rsp_valid), '0);
    chk("R1", "tgt_rd in reset", DW'(tgt_rd), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "rsp_valid after reset", DW'(rsp_valid), '0);
    chk("R1", "tgt_rd after reset", DW'(tgt_rd), '0);
    started = 1;
    @(negedge clk);

    // R6: constant value, stops at 51st sample
    for (int i = 0; i < NS; i++) pat[i] = 32'h1234_5678;
    run_req("R6", 8'h21, 0);
    // R5: all distinct, first sample wins
    for (int i = 0; i < NS; i++) pat[i] = 32'h0000_0007 + 32'(i * 3);
    run_req("R5", 8'h42, 0);
    // R5: exact tie, B reaches 50 first
    for (int i = 0; i < NS; i++) pat[i] = (i % 2 == 0) ? 32'hBBBB_0000 : 32'hAAAA_0000;
    run_req("R5", 8'h43, 0);
    // R4: no majority, mode wins after a full walk
    for (int i = 0; i < NS; i++)
      pat[i] = (i % 20 < 8) ? 32'hC0DE_0001 : (i % 20 < 15) ? 32'hC0DE_0002 : 32'hC0DE_0003;
    run_req("R4", 8'h10, 0);
    // R8: noisy value with glitches, early stop partway
    for (int i = 0; i < NS; i++) pat[i] = (i % 7 == 3) ? 32'(i) : 32'hFEED_F00D;
    run_req("R8", 8'h55, 0);
    // R3: request during capture and during counting is dropped
    for (int i = 0; i < NS; i++) pat[i] = (i % 3 == 0) ? 32'h0000_0011 : 32'(i);
    run_req("R3", 8'h66, 20);
    run_req("R3", 8'h67, 150);
    // R3: request held through the response cycle; re-accepted after it
    begin
      int base;
      cur_tag = "R3";
      base = n_done;
      @(negedge clk); req_valid = 1'b1; req_addr = 8'h77;
      while (n_done < base + 2) @(negedge clk);
      req_valid = 1'b0;
      while (m_busy) @(negedge clk);
      repeat (2) @(negedge clk);
    end
    // R9: a fresh request must not inherit counts from the previous one
    for (int i = 0; i < NS; i++) pat[i] = (i < 45) ? 32'h9999_0001 : 32'(i);
    run_req("R9", 8'h01, 0);
    for (int i = 0; i < NS; i++) pat[i] = (i < 30) ? 32'(i) : (i < 60) ? 32'h9999_0002 : 32'h9999_0001;
    run_req("R9", 8'h02, 0);
    // R7: single pulse with result
    for (int i = 0; i < NS; i++) pat[i] = (i % 4 == 0) ? 32'hDEAD_0000 : 32'h5A5A_5A5A;
    run_req("R7", 8'hF0, 0);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule